// File: doc/BRIEF.md
# CAN Frame Field Decoder

This block takes a CAN bit stream that has already been sampled and synchronised elsewhere. It receives one bit for each strobe of `bit_valid`. It removes stuff bits, counts field positions on the destuffed stream and splits base and extended frames into their fields. It also checks the received CRC against a locally computed one and reports whether the acknowledge slot was driven dominant.

The results are registered once, when a frame completes. At that point `frame_done` pulses, and the parsed fields stay stable until the next frame completes. A stuffing violation or a dominant bit where a recessive delimiter or end-of-frame bit belongs aborts the frame. Such an abort pulses a dedicated error flag and returns the decoder to idle without touching the held fields. Field positions are counted on the destuffed stream. The layout after the IDE position depends on the frame type. Every trailer position is derived from the last data bit, which in turn follows from the DLC and the RTR bit.

Top module: `can_frame_decoder`

## Requirements
- R1: While idle, recessive (1) bits are ignored and produce no pulse on `frame_done`, `err_stuff` or `err_form`. The first dominant (0) bit is taken as start of frame, at destuffed position 0.
- R2: Stuff checking runs from the bit after start of frame up to and including the raw bit that follows the last CRC bit. A raw bit that follows five equal raw bits, and is their complement, is discarded and never shifts a field position. A discarded bit counts as the first bit of the next run.
- R3: A raw bit in a stuff position that equals the five bits before it pulses `err_stuff` for one cycle. It also abandons the frame without a `frame_done` pulse and returns the decoder to idle.
- R4: For a base frame (position 13 dominant), `id_out[10:0]` holds positions 1–11 MSB first and `id_out[28:11]` is zero. `is_ext` is 0 and `is_remote` is the bit at position 12. The reserved bit at 14 may take either value, and the DLC sits at 15–18 MSB first.
- R5: For an extended frame (position 13 recessive), `id_out` is the 11-bit base part in bits 28:18 above the 18-bit extension taken from positions 14–31. `is_ext` is 1 and `is_remote` is the bit at position 32. Positions 33 and 34 may take either value, and the DLC sits at 35–38.
- R6: `dlc_out` is the received 4-bit DLC. The number of data bytes is min(DLC, 8) for data frames and zero for remote frames. Byte k lands in `data_out[63-8k -: 8]`, MSB first, and bytes not received read zero.
- R7: `crc_rx` holds the 15 bits that follow the last data bit, MSB first. `crc_ok` is 1 exactly when they equal the CRC-15 (polynomial 0x4599, initial value 0, MSB first) of the destuffed bits from start of frame through the last data bit.
- R8: `ack_ok` is 1 when the bit at last+17 (the acknowledge slot) is dominant, and 0 when it is recessive.
- R9: `frame_done` pulses for exactly one cycle, in the cycle after the strobe that carries the bit at last+25 (the seventh end-of-frame bit). All field outputs update in that same cycle and hold until the next `frame_done`.
- R10: A dominant bit at last+16 (CRC delimiter), at last+18 (ACK delimiter) or at any of last+19 to last+25 (end of frame) pulses `err_form`. The frame is then abandoned without `frame_done`, and the previous field outputs are kept.
- R11: After a completed or abandoned frame, the decoder is idle, and the next dominant bit starts a new frame that decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Strobe: `rx_bit` carries one new raw bus bit |
| rx_bit | input | 1 | Raw bus bit, 0 dominant, 1 recessive |
| frame_done | output | 1 | One-cycle pulse when a frame completes |
| err_stuff | output | 1 | One-cycle pulse on a stuffing violation |
| err_form | output | 1 | One-cycle pulse on a dominant fixed-recessive bit |
| id_out | output | 29 | Identifier of the last completed frame |
| is_ext | output | 1 | Last frame used the extended format |
| is_remote | output | 1 | Last frame was a remote frame |
| dlc_out | output | 4 | Received DLC |
| data_out | output | 64 | Data bytes, byte 0 in the top byte |
| crc_rx | output | 15 | Received CRC field |
| crc_ok | output | 1 | Received CRC matches the computed CRC |
| ack_ok | output | 1 | Acknowledge slot was dominant |

## Verification
The assertions assume that `bit_valid` carries exactly one bus bit per strobe, with no repeated or skipped bits. They also assume that `rx_bit` is stable in the cycle it is strobed. The stimulus builds every frame from the field layout, stuffs it and walks it one bit per strobe, with random idle cycles between strobes. Only selected bits are deliberately corrupted. After an injected stuff or form fault, the bench stops feeding the rest of that frame and sends recessive idle bits instead. This keeps leftover dominant bits from being taken as a false start of frame, so each event pulse can be tied to one frame.

// File: rtl/can_dec_pkg.sv
`timescale 1ns/1ps
package can_dec_pkg;
    localparam int BASE_ID_W = 11;
    localparam int EXT_ID_W  = 18;
    localparam int FULL_ID_W = BASE_ID_W + EXT_ID_W;
    localparam int DLC_W     = 4;
    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = 8 * MAX_BYTES;
    localparam int IDX_W     = $clog2(DATA_W);
    localparam int CRC_W     = 15;
    localparam int POS_W     = 8;
    localparam int RUN_LEN   = 5;
    localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;

    // destuffed field positions
    localparam logic [POS_W-1:0] P_ID_LO   = 8'd1;
    localparam logic [POS_W-1:0] P_ID_HI   = 8'd11;
    localparam logic [POS_W-1:0] P_RTR_STD = 8'd12;
    localparam logic [POS_W-1:0] P_IDE     = 8'd13;
    localparam logic [POS_W-1:0] P_SDLC_LO = 8'd15;
    localparam logic [POS_W-1:0] P_SHDR    = 8'd18;
    localparam logic [POS_W-1:0] P_XID_LO  = 8'd14;
    localparam logic [POS_W-1:0] P_XID_HI  = 8'd31;
    localparam logic [POS_W-1:0] P_RTR_EXT = 8'd32;
    localparam logic [POS_W-1:0] P_XDLC_LO = 8'd35;
    localparam logic [POS_W-1:0] P_XHDR    = 8'd38;
    // trailer offsets relative to the last data bit
    localparam logic [POS_W-1:0] T_CRC_END = 8'd15;
    localparam logic [POS_W-1:0] T_CRC_DEL = 8'd16;
    localparam logic [POS_W-1:0] T_ACK     = 8'd17;
    localparam logic [POS_W-1:0] T_END     = 8'd25;

    typedef struct packed {
        logic [FULL_ID_W-1:0] id;
        logic                 ext;
        logic                 remote;
        logic [DLC_W-1:0]     dlc;
        logic [DATA_W-1:0]    data;
        logic [CRC_W-1:0]     crc_rx;
        logic                 crc_ok;
        logic                 ack;
    } frame_info_t;

    function automatic logic [CRC_W-1:0] crc15_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic [DLC_W-1:0] byte_count(input logic [DLC_W-1:0] dlc, input logic remote);
        if (remote) return '0;
        if (dlc > DLC_W'(MAX_BYTES)) return DLC_W'(MAX_BYTES);
        return dlc;
    endfunction
endpackage

// File: rtl/can_destuff.sv
`timescale 1ns/1ps
module can_destuff
    import can_dec_pkg::*;
#(
    parameter int RUN = RUN_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic rx_bit,
    input  logic seg_on,
    output logic d_valid,
    output logic d_bit,
    output logic stuff_err
);
    localparam int RCW = $clog2(RUN + 1);

    logic [RCW-1:0] run_cnt;
    logic           last_bit;
    logic           stuff_slot;

    always_comb begin
        stuff_slot = seg_on && (run_cnt == RCW'(RUN));
        d_valid    = bit_valid && !stuff_slot;
        d_bit      = rx_bit;
        stuff_err  = bit_valid && stuff_slot && (rx_bit == last_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            last_bit <= 1'b1;
        end else if (bit_valid) begin
            if (!seg_on || stuff_slot || rx_bit != last_bit)
                run_cnt <= RCW'(1);
            else
                run_cnt <= run_cnt + RCW'(1);
            last_bit <= rx_bit;
        end
    end

    // R2: the run counter never passes the stuff limit while stuffing is active
    assert_run_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        seg_on |-> run_cnt <= RCW'(RUN));
endmodule

// File: rtl/can_crc15.sv
`timescale 1ns/1ps
module can_crc15
    import can_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            crc <= '0;
        else if (en)
            crc <= crc15_step(crc, din);
    end

    assert_crc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/can_field_parse.sv
`timescale 1ns/1ps
module can_field_parse
    import can_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             d_valid,
    input  logic             d_bit,
    input  logic             stuff_err,
    input  logic [CRC_W-1:0] crc_calc,
    output logic             seg_on,
    output logic             crc_clr,
    output logic             crc_en,
    output logic             frame_done,
    output logic             err_stuff,
    output logic             err_form,
    output frame_info_t      info
);
    logic                 busy, len_known, ide, rtr, ack;
    logic [POS_W-1:0]     pos, last, hdr_end;
    logic [BASE_ID_W-1:0] base_id;
    logic [EXT_ID_W-1:0]  ext_id;
    logic [DLC_W-1:0]     dlc, dlc_nxt, nbytes;
    logic [DATA_W-1:0]    data;
    logic [CRC_W-1:0]     crc_sh;
    logic [IDX_W-1:0]     bit_idx;

    always_comb begin
        hdr_end = ide ? P_XHDR : P_SHDR;
        seg_on  = busy && (!len_known || pos <= last + T_CRC_DEL);
        crc_clr = !busy;
        crc_en  = busy && d_valid && (!len_known || pos <= last);
        dlc_nxt = {dlc[DLC_W-2:0], d_bit};
        nbytes  = byte_count(dlc_nxt, rtr);
        bit_idx = IDX_W'(pos - hdr_end - POS_W'(1));
    end

    always_ff @(posedge clk) begin
        frame_done <= 1'b0;
        err_stuff  <= 1'b0;
        err_form   <= 1'b0;
        if (rst) begin
            busy <= 1'b0; len_known <= 1'b0; pos <= '0; last <= '0;
            ide <= 1'b0; rtr <= 1'b0; ack <= 1'b0; dlc <= '0;
            base_id <= '0; ext_id <= '0; data <= '0; crc_sh <= '0;
            info <= '0;
        end else if (busy && stuff_err) begin
            err_stuff <= 1'b1;
            busy      <= 1'b0;
        end else if (d_valid) begin
            if (!busy) begin
                if (!d_bit) begin
                    busy <= 1'b1; pos <= P_ID_LO; len_known <= 1'b0; last <= '0;
                    ide <= 1'b0; rtr <= 1'b0; ack <= 1'b0; dlc <= '0;
                    base_id <= '0; ext_id <= '0; data <= '0; crc_sh <= '0;
                end
            end else begin
                pos <= pos + POS_W'(1);
                if (!len_known) begin
                    if (pos >= P_ID_LO && pos <= P_ID_HI)
                        base_id <= {base_id[BASE_ID_W-2:0], d_bit};
                    else if (pos == P_RTR_STD)
                        rtr <= d_bit;
                    else if (pos == P_IDE)
                        ide <= d_bit;
                    else if (!ide) begin
                        if (pos >= P_SDLC_LO) dlc <= dlc_nxt;
                        if (pos == P_SHDR) begin
                            len_known <= 1'b1;
                            last      <= P_SHDR + POS_W'({nbytes, 3'b000});
                        end
                    end else begin
                        if (pos >= P_XID_LO && pos <= P_XID_HI)
                            ext_id <= {ext_id[EXT_ID_W-2:0], d_bit};
                        if (pos == P_RTR_EXT) rtr <= d_bit;
                        if (pos >= P_XDLC_LO) dlc <= dlc_nxt;
                        if (pos == P_XHDR) begin
                            len_known <= 1'b1;
                            last      <= P_XHDR + POS_W'({nbytes, 3'b000});
                        end
                    end
                end else begin
                    if (pos <= last)
                        data[~bit_idx] <= d_bit;
                    else if (pos <= last + T_CRC_END)
                        crc_sh <= {crc_sh[CRC_W-2:0], d_bit};
                    else if (pos == last + T_ACK)
                        ack <= !d_bit;
                    else if (!d_bit) begin
                        err_form <= 1'b1;
                        busy     <= 1'b0;
                    end else if (pos == last + T_END) begin
                        busy        <= 1'b0;
                        frame_done  <= 1'b1;
                        info.id     <= ide ? {base_id, ext_id} : FULL_ID_W'(base_id);
                        info.ext    <= ide;
                        info.remote <= rtr;
                        info.dlc    <= dlc;
                        info.data   <= data;
                        info.crc_rx <= crc_sh;
                        info.crc_ok <= (crc_sh == crc_calc);
                        info.ack    <= ack;
                    end
                end
            end
        end
    end

    assert_event_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_done, err_stuff, err_form}));
    assert_done_after_bit_R9: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(d_valid));
    assert_pos_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && len_known) |-> pos <= last + T_END);
    assert_last_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        len_known |-> (last >= hdr_end && last <= hdr_end + POS_W'(DATA_W)
                       && (((last - hdr_end) & POS_W'(7)) == '0)));
    assert_stuff_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
        err_stuff |-> $past(busy));
endmodule

// File: rtl/can_frame_decoder.sv
`timescale 1ns/1ps
module can_frame_decoder
    import can_dec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_valid,
    input  logic                 rx_bit,
    output logic                 frame_done,
    output logic                 err_stuff,
    output logic                 err_form,
    output logic [FULL_ID_W-1:0] id_out,
    output logic                 is_ext,
    output logic                 is_remote,
    output logic [DLC_W-1:0]     dlc_out,
    output logic [DATA_W-1:0]    data_out,
    output logic [CRC_W-1:0]     crc_rx,
    output logic                 crc_ok,
    output logic                 ack_ok
);
    logic             d_valid, d_bit, stuff_err, seg_on, crc_clr, crc_en;
    logic [CRC_W-1:0] crc_calc;
    frame_info_t      info;

    can_destuff #(.RUN(RUN_LEN)) u_destuff (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .rx_bit(rx_bit),
        .seg_on(seg_on), .d_valid(d_valid), .d_bit(d_bit), .stuff_err(stuff_err)
    );

    can_crc15 u_crc (
        .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(d_bit), .crc(crc_calc)
    );

    can_field_parse u_parse (
        .clk(clk), .rst(rst), .d_valid(d_valid), .d_bit(d_bit), .stuff_err(stuff_err),
        .crc_calc(crc_calc), .seg_on(seg_on), .crc_clr(crc_clr), .crc_en(crc_en),
        .frame_done(frame_done), .err_stuff(err_stuff), .err_form(err_form), .info(info)
    );

    assign id_out    = info.id;
    assign is_ext    = info.ext;
    assign is_remote = info.remote;
    assign dlc_out   = info.dlc;
    assign data_out  = info.data;
    assign crc_rx    = info.crc_rx;
    assign crc_ok    = info.crc_ok;
    assign ack_ok    = info.ack;
endmodule

// File: tb/tb_can_frame_decoder.sv
`timescale 1ns/1ps
module tb_can_frame_decoder;
    logic clk = 1'b0, rst = 1'b1, bit_valid = 1'b0, rx_bit = 1'b1;
    logic frame_done, err_stuff, err_form, is_ext, is_remote, crc_ok, ack_ok;
    logic [28:0] id_out;
    logic [3:0]  dlc_out;
    logic [63:0] data_out;
    logic [14:0] crc_rx;

    can_frame_decoder dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .rx_bit(rx_bit),
        .frame_done(frame_done), .err_stuff(err_stuff), .err_form(err_form),
        .id_out(id_out), .is_ext(is_ext), .is_remote(is_remote), .dlc_out(dlc_out),
        .data_out(data_out), .crc_rx(crc_rx), .crc_ok(crc_ok), .ack_ok(ack_ok)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic dbits [0:159];
    logic raw   [0:255];
    int dlen, raw_len, tr_start, first_stuff;
    int n_done, n_sterr, n_ferr, done_idx, sterr_idx, ferr_idx;
    logic [28:0] e_id;  logic e_ext, e_rem;  logic [3:0] e_dlc;
    logic [63:0] e_data; logic [14:0] e_crc;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] crc_step(input logic [14:0] c, input logic b);
        logic fb;
        fb = b ^ c[14];
        return {c[13:0], 1'b0} ^ (fb ? 15'h4599 : 15'h0);
    endfunction

    task automatic build(input bit ext, input logic [28:0] id, input bit rtr,
                         input logic [3:0] dlc, input logic [63:0] data,
                         input bit r0, input bit r1, input logic [14:0] crc_flip);
        int p = 0;
        int nb, run;
        logic lastb;
        logic [10:0] base;
        logic [14:0] c = '0;
        base = ext ? id[28:18] : id[10:0];
        dbits[p++] = 1'b0;
        for (int i = 10; i >= 0; i--) dbits[p++] = base[i];
        dbits[p++] = ext ? 1'b1 : rtr;
        dbits[p++] = ext;
        if (ext) begin
            for (int i = 17; i >= 0; i--) dbits[p++] = id[i];
            dbits[p++] = rtr; dbits[p++] = r1; dbits[p++] = r0;
        end else dbits[p++] = r0;
        for (int i = 3; i >= 0; i--) dbits[p++] = dlc[i];
        nb = rtr ? 0 : (dlc > 8 ? 8 : int'(dlc));
        for (int i = 0; i < nb * 8; i++) dbits[p++] = data[63 - i];
        for (int i = 0; i < p; i++) c = crc_step(c, dbits[i]);
        c ^= crc_flip;
        for (int i = 14; i >= 0; i--) dbits[p++] = c[i];
        dlen = p;
        raw_len = 0; run = 0; lastb = 1'b1; first_stuff = -1;
        for (int i = 0; i < dlen; i++) begin
            raw[raw_len++] = dbits[i];
            if (i == 0 || dbits[i] != lastb) run = 1; else run++;
            lastb = dbits[i];
            if (run == 5) begin
                if (first_stuff < 0) first_stuff = raw_len;
                raw[raw_len++] = !lastb;
                lastb = !lastb; run = 1;
            end
        end
        tr_start = raw_len;
        raw[raw_len++] = 1'b1; raw[raw_len++] = 1'b0; raw[raw_len++] = 1'b1;
        for (int i = 0; i < 7; i++) raw[raw_len++] = 1'b1;
        e_id = ext ? id : {18'b0, id[10:0]};
        e_ext = ext; e_rem = rtr; e_dlc = dlc; e_crc = c;
        e_data = (nb == 0) ? 64'h0 : (data & (~64'h0 << (64 - 8 * nb)));
    endtask

    task automatic tick(input int idx);
        @(posedge clk); #1;
        if (frame_done) begin n_done++; done_idx = idx; end
        if (err_stuff)  begin n_sterr++; sterr_idx = idx; end
        if (err_form)   begin n_ferr++; ferr_idx = idx; end
    endtask

    task automatic send_bit(input logic b, input int idx);
        @(negedge clk); bit_valid = 1'b1; rx_bit = b;
        tick(idx);
        @(negedge clk); bit_valid = 1'b0;
        if ($urandom % 4 == 0) tick(-1);
    endtask

    // send raw bits 0..upto, then recessive idle
    task automatic send_frame(input int upto);
        n_done = 0; n_sterr = 0; n_ferr = 0; done_idx = -1; sterr_idx = -1; ferr_idx = -1;
        for (int i = 0; i <= upto; i++) send_bit(raw[i], i);
        for (int i = 0; i < 12; i++) send_bit(1'b1, -2);
    endtask

    task automatic check_good(input string tag);
        check({tag, " R9 done count"}, 64'(n_done), 64'd1);
        check({tag, " R9 done timing"}, 64'(done_idx), 64'(raw_len - 1));
        check({tag, " R3 no stuff err"}, 64'(n_sterr), 64'd0);
        check({tag, " R10 no form err"}, 64'(n_ferr), 64'd0);
        check({tag, " R4 R5 id"}, 64'(id_out), 64'(e_id));
        check({tag, " R4 R5 ext"}, 64'(is_ext), 64'(e_ext));
        check({tag, " R4 R5 remote"}, 64'(is_remote), 64'(e_rem));
        check({tag, " R6 dlc"}, 64'(dlc_out), 64'(e_dlc));
        check({tag, " R6 data"}, data_out, e_data);
        check({tag, " R7 crc_rx"}, 64'(crc_rx), 64'(e_crc));
    endtask

    initial begin
        #1200000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [28:0] held_id;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("reset R9 done", 64'(frame_done), 64'd0);
        check("reset R9 id", 64'(id_out), 64'd0);
        check("reset R9 data", data_out, 64'd0);

        // R1: recessive idle bits do nothing
        n_done = 0; n_sterr = 0; n_ferr = 0;
        for (int i = 0; i < 30; i++) send_bit(1'b1, -3);
        check("idle R1 events", 64'(n_done + n_sterr + n_ferr), 64'd0);

        // R2: all-zero base frame, dense stuffing
        build(0, 29'h0, 0, 4'd2, 64'h0, 0, 0, 15'h0);
        send_frame(raw_len - 1);
        check_good("zero-id R2");
        check("zero-id R7 crc_ok", 64'(crc_ok), 64'd1);
        check("zero-id R8 ack", 64'(ack_ok), 64'd1);

        // R2 R5: extended, all ones
        build(1, 29'h1FFFFFFF, 0, 4'd8, 64'hFFFFFFFFFFFFFFFF, 1, 1, 15'h0);
        send_frame(raw_len - 1);
        check_good("ones-ext R2 R5");
        check("ones-ext R7 crc_ok", 64'(crc_ok), 64'd1);

        // R6: DLC above 8, and remote with DLC 5
        build(0, 29'h5A5, 0, 4'd12, 64'h0123456789ABCDEF, 1, 0, 15'h0);
        send_frame(raw_len - 1);
        check_good("dlc12 R6");
        build(1, 29'h12345678, 1, 4'd5, 64'hDEADBEEFDEADBEEF, 0, 1, 15'h0);
        send_frame(raw_len - 1);
        check_good("remote R6");

        // R7: corrupted CRC still completes with crc_ok=0
        build(0, 29'h3C1, 0, 4'd3, 64'hA1B2C3000000000, 0, 0, 15'h0010);
        send_frame(raw_len - 1);
        check_good("badcrc R7");
        check("badcrc R7 crc_ok", 64'(crc_ok), 64'd0);

        // R8: NACK
        build(1, 29'h0ABCDEF1, 0, 4'd1, 64'h7700000000000000, 0, 0, 15'h0);
        raw[tr_start + 1] = 1'b1;
        send_frame(raw_len - 1);
        check_good("nack R8");
        check("nack R8 ack", 64'(ack_ok), 64'd0);
        held_id = id_out;

        // R10: dominant CRC delimiter
        build(0, 29'h111, 0, 4'd1, 64'h5500000000000000, 0, 0, 15'h0);
        raw[tr_start] = 1'b0;
        send_frame(tr_start);
        check("crcdel R10 form err", 64'(n_ferr), 64'd1);
        check("crcdel R10 no done", 64'(n_done), 64'd0);
        check("crcdel R10 held id", 64'(id_out), 64'(held_id));

        // R10: dominant end-of-frame bit
        build(1, 29'h00FF00FF, 0, 4'd0, 64'h0, 0, 0, 15'h0);
        raw[tr_start + 6] = 1'b0;
        send_frame(tr_start + 6);
        check("eof R10 form err", 64'(n_ferr), 64'd1);
        check("eof R10 err timing", 64'(ferr_idx), 64'(tr_start + 6));
        check("eof R10 no done", 64'(n_done), 64'd0);

        // R10: dominant ACK delimiter
        build(0, 29'h2AA, 0, 4'd0, 64'h0, 0, 0, 15'h0);
        raw[tr_start + 2] = 1'b0;
        send_frame(tr_start + 2);
        check("ackdel R10 form err", 64'(n_ferr), 64'd1);

        // R3: broken stuff bit
        build(0, 29'h0, 0, 4'd4, 64'h0, 0, 0, 15'h0);
        raw[first_stuff] = !raw[first_stuff];
        send_frame(first_stuff);
        check("stuff R3 err", 64'(n_sterr), 64'd1);
        check("stuff R3 err timing", 64'(sterr_idx), 64'(first_stuff));
        check("stuff R3 no done", 64'(n_done), 64'd0);
        check("stuff R3 held id", 64'(id_out), 64'(held_id));

        // R11: decoding resumes after an abort
        build(0, 29'h7F0, 0, 4'd8, 64'hF0E1D2C3B4A59687, 0, 0, 15'h0);
        send_frame(raw_len - 1);
        check_good("resume R11");
        check("resume R11 crc_ok", 64'(crc_ok), 64'd1);

        // random frames covering R1..R9, R11
        for (int k = 0; k < 40; k++) begin
            bit ext, rtr;
            logic [28:0] id;
            logic [63:0] d;
            ext = 1'($urandom);
            rtr = ($urandom % 4 == 0);
            id  = 29'($urandom);
            d   = {$urandom, $urandom};
            build(ext, id, rtr, 4'($urandom), d, 1'($urandom), 1'($urandom), 15'h0);
            send_frame(raw_len - 1);
            check_good("random R4 R5 R6 R11");
            check("random R7 crc_ok", 64'(crc_ok), 64'd1);
            check("random R8 ack", 64'(ack_ok), 64'd1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule